// File: doc/BRIEF.md
# Motor Stall Protection Timer

This block decides whether a brushless motor is turning by watching one Hall sensor line, and it throttles the drive with a slow automatic-retry pattern when the motor is stuck. A digital level counter stands in for a timing capacitor. A fixed prescaler produces a tick every `TICK_DIV` clocks, and the level climbs by `CHG_STEP` on each tick. Every transition of the Hall line, whether rising or falling, removes `EDGE_Q` from the level. A spinning motor therefore holds the level at a point set by its speed. A motor that stops, or turns too slowly, lets the level climb to the upper threshold `LVL_HI`.

When the level reaches `LVL_HI` the controller leaves **RUN** (transition *STALL*) and enters **HOLD_OFF**. In that state the drive is blocked and the level sinks by `DIS_STEP` per tick. When the level is at or below `LVL_LO` the controller moves to **RETRY_ON** (transition *RETRY*). There the drive is allowed again and the level climbs at the charge rate. Reaching `LVL_HI` again returns it to HOLD_OFF (transition *BACKOFF*). With the default `CHG_STEP = 14 × DIS_STEP` the drive is on for one part in fifteen of each retry period. Any Hall edge seen in HOLD_OFF or RETRY_ON returns the controller to RUN (transition *RELEASE*). A low protection enable forces RUN and reloads the level with `LVL_LO` (transition *DISABLE*).

The block is meant to sit between a synchronised Hall input and the low-side gate logic of a motor driver. It gates that logic through `drive_ok` and reports a stall on `stall_flag`.

Top module: `stall_guard`

## Requirements
- R1: After reset the controller is in RUN with `stall_flag` = 0 and `drive_ok` = 1, and the level starts at `LVL_LO`. With no Hall edges and the enable high, the first stall therefore follows exactly (LVL_HI-LVL_LO)/CHG_STEP ticks after reset.
- R2: In RUN and RETRY_ON the level rises by `CHG_STEP` on each prescaler tick, one tick every `TICK_DIV` clocks. When the level reaches `LVL_HI` in RUN, `stall_flag` goes to 1 one clock later. With the defaults this is at the 17th rising clock edge after reset.
- R3: Both a rising and a falling Hall transition lower the level by `EDGE_Q`. With periodic transitions every P clocks, a stall occurs exactly when (P/TICK_DIV)·CHG_STEP > EDGE_Q.
- R4: In HOLD_OFF, `drive_ok` = 0, and the level falls by `DIS_STEP` per tick until it is at or below `LVL_LO`. With the defaults this takes 224 clocks.
- R5: In RETRY_ON, `drive_ok` = 1 until the level reaches `LVL_HI` again. With the defaults this takes 16 clocks, so the on:off ratio equals DIS_STEP:CHG_STEP = 1:14.
- R6: `stall_flag` (1 = stalled) is 1 in HOLD_OFF and RETRY_ON and 0 in RUN.
- R7: A Hall transition in HOLD_OFF or RETRY_ON returns the controller to RUN on the next clock, with `stall_flag` = 0 and `drive_ok` = 1.
- R8: While `prot_en` = 0, `drive_ok` = 1 and `stall_flag` = 0 in the same cycle. The controller is held in RUN with the level at `LVL_LO`, so after re-enabling, a stall needs the full `LVL_HI - LVL_LO` rise again.
- R9: The level saturates at 0 and at its maximum. After edges have pinned it at 0, a stall needs ceil(LVL_HI/CHG_STEP) ticks once the edges stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_in | input | 1 | Synchronised level of the observed Hall sensor |
| prot_en | input | 1 | 1 enables stall protection |
| drive_ok | output | 1 | 1 allows the low-side drive |
| stall_flag | output | 1 | 1 while the motor is judged stalled |

## Verification
A Hall transition driven before clock edge k lowers the level at edge k. A level crossing changes the state, and so both outputs, one edge after the level register holds the crossing value. A change on `prot_en` acts on the outputs combinationally, in the same cycle. The bench samples on falling edges and counts rising edges from the release of reset, so exact-time checks land on the first cycle an output may change. Where the prescaler phase is unknown, after a re-enable or after the last of a burst of edges, the checks bracket a window: they take the latest edge on which the output must still be unchanged and the earliest edge by which it must have moved.

// File: rtl/stall_guard_pkg.sv
package stall_guard_pkg;

    typedef enum logic [1:0] {
        SG_RUN      = 2'd0,
        SG_HOLD_OFF = 2'd1,
        SG_RETRY_ON = 2'd2
    } sg_state_t;

endpackage

// File: rtl/sg_tick_gen.sv
module sg_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (TICK_DIV > 1) begin : g_spacing
            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/sg_edge_det.sv
module sg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_in,
    output logic hall_edge
);
    logic hall_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hall_q <= 1'b0;
        else
            hall_q <= hall_in;
    end

    assign hall_edge = hall_in ^ hall_q;
endmodule

// File: rtl/sg_level.sv
module sg_level #(
    parameter int LVL_W    = 8,
    parameter int CHG_STEP = 14,
    parameter int DIS_STEP = 1,
    parameter int EDGE_Q   = 56,
    parameter int LVL_LO   = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_en,
    input  logic             tick,
    input  logic             charging,
    input  logic             draining,
    input  logic             hall_edge,
    output logic [LVL_W-1:0] level
);
    localparam int SW = LVL_W + 2;
    localparam logic signed [SW-1:0] S_MAX = SW'((1 << LVL_W) - 1);
    localparam logic [LVL_W-1:0] LO_V = LVL_W'(LVL_LO);

    logic signed [SW-1:0] sum;
    logic [LVL_W-1:0]     level_nx;

    always_comb begin
        sum = $signed({2'b00, level});
        if (tick && charging)
            sum = sum + SW'(CHG_STEP);
        if (tick && draining)
            sum = sum - SW'(DIS_STEP);
        if (hall_edge)
            sum = sum - SW'(EDGE_Q);
        if (sum < 0)
            level_nx = '0;
        else if (sum > S_MAX)
            level_nx = S_MAX[LVL_W-1:0];
        else
            level_nx = sum[LVL_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            level <= LO_V;
        else if (!prot_en)
            level <= LO_V;
        else
            level <= level_nx;
    end

    // R4
    level_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && draining && !hall_edge) |=> level <= $past(level));

    // R8
    level_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |=> level == LO_V);

    // R9
    level_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && charging && !hall_edge) |=> level >= $past(level));
endmodule

// File: rtl/sg_fsm.sv
module sg_fsm
    import stall_guard_pkg::*;
#(
    parameter int LVL_W  = 8,
    parameter int LVL_LO = 28,
    parameter int LVL_HI = 84
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prot_en,
    input  logic             hall_edge,
    input  logic [LVL_W-1:0] level,
    output logic             charging,
    output logic             draining,
    output logic             drive_ok,
    output logic             stall_flag
);
    localparam logic [LVL_W-1:0] LO_V = LVL_W'(LVL_LO);
    localparam logic [LVL_W-1:0] HI_V = LVL_W'(LVL_HI);

    sg_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SG_RUN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        if (!prot_en) begin
            state_nx = SG_RUN;                      // DISABLE
        end else begin
            unique case (state)
                SG_RUN: begin
                    if (level >= HI_V)
                        state_nx = SG_HOLD_OFF;     // STALL
                end
                SG_HOLD_OFF: begin
                    if (hall_edge)
                        state_nx = SG_RUN;          // RELEASE
                    else if (level <= LO_V)
                        state_nx = SG_RETRY_ON;     // RETRY
                end
                SG_RETRY_ON: begin
                    if (hall_edge)
                        state_nx = SG_RUN;          // RELEASE
                    else if (level >= HI_V)
                        state_nx = SG_HOLD_OFF;     // BACKOFF
                end
                default: state_nx = SG_RUN;
            endcase
        end
    end

    always_comb begin
        charging   = 1'b1;
        draining   = 1'b0;
        drive_ok   = 1'b1;
        stall_flag = 1'b0;
        unique case (state)
            SG_RUN: ;
            SG_HOLD_OFF: begin
                charging   = 1'b0;
                draining   = 1'b1;
                drive_ok   = !prot_en;
                stall_flag = prot_en;
            end
            SG_RETRY_ON: begin
                stall_flag = prot_en;
            end
            default: ;
        endcase
    end

    // R2
    stall_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall_flag) |-> $past(level) >= HI_V);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && stall_flag && hall_edge) |=> !stall_flag && drive_ok);

    // R6
    drive_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_ok) |-> stall_flag);

    // R8
    disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> drive_ok && !stall_flag);

    // R5
    retry_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && !$past(drive_ok) && drive_ok && stall_flag) |-> $past(level) <= LO_V);
endmodule

// File: rtl/stall_guard.sv
module stall_guard #(
    parameter int LVL_W    = 8,
    parameter int TICK_DIV = 4,
    parameter int CHG_STEP = 14,
    parameter int DIS_STEP = 1,
    parameter int EDGE_Q   = 56,
    parameter int LVL_LO   = 28,
    parameter int LVL_HI   = 84
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hall_in,
    input  logic prot_en,
    output logic drive_ok,
    output logic stall_flag
);
    logic             tick;
    logic             hall_edge;
    logic             charging;
    logic             draining;
    logic [LVL_W-1:0] level;

    sg_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    sg_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .hall_in  (hall_in),
        .hall_edge(hall_edge)
    );

    sg_level #(
        .LVL_W   (LVL_W),
        .CHG_STEP(CHG_STEP),
        .DIS_STEP(DIS_STEP),
        .EDGE_Q  (EDGE_Q),
        .LVL_LO  (LVL_LO)
    ) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .prot_en  (prot_en),
        .tick     (tick),
        .charging (charging),
        .draining (draining),
        .hall_edge(hall_edge),
        .level    (level)
    );

    sg_fsm #(
        .LVL_W (LVL_W),
        .LVL_LO(LVL_LO),
        .LVL_HI(LVL_HI)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .prot_en   (prot_en),
        .hall_edge (hall_edge),
        .level     (level),
        .charging  (charging),
        .draining  (draining),
        .drive_ok  (drive_ok),
        .stall_flag(stall_flag)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> drive_ok && !stall_flag);
endmodule

// File: tb/stall_guard_tb_top.sv
module stall_guard_tb_top;
    localparam int TDIV = 4;
    localparam int CHG  = 14;
    localparam int DIS  = 1;
    localparam int EQ   = 56;
    localparam int LO   = 28;
    localparam int HI   = 84;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hall = 1'b0;
    logic en = 1'b1;
    logic drive_ok, stall_flag;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    stall_guard #(
        .TICK_DIV(TDIV), .CHG_STEP(CHG), .DIS_STEP(DIS),
        .EDGE_Q(EQ), .LVL_LO(LO), .LVL_HI(HI)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .hall_in(hall), .prot_en(en),
        .drive_ok(drive_ok), .stall_flag(stall_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        hall = 1'b0;
        en = 1'b1;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rise_edges = (HI - LO) / CHG * TDIV;
        int cnt;
        int seen;

        do_reset();
        chk("R1 flag at reset", stall_flag, 0);
        chk("R1 drive at reset", drive_ok, 1);

        step(rise_edges);
        chk("R2 no stall before HI", stall_flag, 0);
        step(1);
        chk("R2 stall one edge after HI", stall_flag, 1);
        chk("R4 drive blocked in hold-off", drive_ok, 0);

        step(223);
        chk("R4 still off at edge 240", drive_ok, 0);
        step(1);
        chk("R5 retry on at edge 241", drive_ok, 1);
        chk("R6 flag stays in retry", stall_flag, 1);
        step(15);
        chk("R5 still on at edge 256", drive_ok, 1);
        step(1);
        chk("R5 back off at edge 257", drive_ok, 0);

        cnt = 1;
        for (int i = 0; i < 1000 && drive_ok == 1'b0; i++) begin
            step(1);
            if (!drive_ok) cnt++;
        end
        chk("R4 off length", cnt, (HI - LO) / DIS * TDIV);
        cnt = 1;
        for (int i = 0; i < 1000 && drive_ok == 1'b1; i++) begin
            step(1);
            if (drive_ok) cnt++;
        end
        chk("R5 on length", cnt, (HI - LO) / CHG * TDIV);

        hall = ~hall;
        step(1);
        chk("R7 release from hold-off flag", stall_flag, 0);
        chk("R7 release from hold-off drive", drive_ok, 1);

        do_reset();
        step(245);
        chk("R5 in retry at edge 245", drive_ok & stall_flag, 1);
        hall = ~hall;
        step(1);
        chk("R7 release from retry", stall_flag, 0);

        for (int k = 0; k < 6; k++) begin
            int p;
            int expect_stall;
            case (k)
                0: p = 4;
                1: p = 8;
                2: p = 12;
                3: p = 20;
                4: p = 24;
                default: p = 32;
            endcase
            expect_stall = ((p / TDIV) * CHG > EQ) ? 1 : 0;
            do_reset();
            seen = 0;
            for (int c = 0; c < 480; c++) begin
                if (c % p == p - 1) hall = ~hall;
                step(1);
                if (stall_flag) seen = 1;
            end
            chk($sformatf("R3 period %0d stall", p), seen, expect_stall);
        end

        do_reset();
        for (int c = 0; c < 200; c++) begin
            if (c % 4 == 3) hall = ~hall;
            step(1);
        end
        step(21);
        chk("R9 floor at zero, no early stall", stall_flag, 0);
        step(4);
        chk("R9 stall after full rise from zero", stall_flag, 1);

        do_reset();
        step(17);
        chk("R2 stall before disable", stall_flag, 1);
        en = 1'b0;
        #1;
        chk("R8 drive same cycle", drive_ok, 1);
        chk("R8 flag same cycle", stall_flag, 0);
        seen = 0;
        for (int c = 0; c < 300; c++) begin
            step(1);
            if (stall_flag || !drive_ok) seen = 1;
        end
        chk("R8 quiet while disabled", seen, 0);
        en = 1'b1;
        step(12);
        chk("R8 level reloaded, no early stall", stall_flag, 0);
        step(5);
        chk("R8 stall after re-enable", stall_flag, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule